// File: doc/BRIEF.md
# Bidirectional Parallel Printer Port Registers

This block places a PC-style printer port behind a small window of host I/O addresses. Three byte-wide registers sit in the window. The data register loads an 8-bit output latch that feeds the eight data lines. The status register shows five printer input lines. The control register drives four printer handshake outputs and also holds an interrupt enable and a direction bit.

The direction bit turns the output enable of the data latch off, so an external device can drive the data lines. A read of the data register always returns the lines as they appear at the pins. In output mode the pins carry the latched byte. In input mode they carry whatever the far end drives. The block compares only part of the address, so the three registers appear a second time four addresses higher.

The host side is a synchronous strobe interface. A write takes effect on the clock edge on which `bus_wr` is high. Read data is combinational while `bus_rd` is high. The pin side has no tri-state buffer: it exposes the latch value, an output enable and the resolved pin value. Printer input lines pass through a synchronizer before they reach the status register and the interrupt output.

Top module: `lpt_port`

## Requirements
- R1: The data register is at `BASE_ADDR`, the status register at `BASE_ADDR+1` and the control register at `BASE_ADDR+2` (default 0x378). A write to an address outside the window changes nothing, and a read of such an address returns 0xFF.
- R2: Address bit `ALIAS_BIT` (default 2) is not compared, so `BASE_ADDR+4`, `+5` and `+6` reach the same data, status and control registers as `+0`, `+1` and `+2`.
- R3: A write to the data register loads all eight bits into the latch, and the latch appears on `pd_out` after that clock edge. Any other access leaves `pd_out` unchanged.
- R4: Control bit 5 selects the direction. When it is 0, `pd_oe` is 1 (output mode). When it is 1, `pd_oe` is 0 (input mode). Data writes made in input mode still load the latch.
- R5: A read of the data register returns `pd_in`, the resolved level on the data pins, in both modes.
- R6: The pin outputs follow the control bits with a fixed polarity: `pin_strobe` = NOT bit 0, `pin_autofd` = NOT bit 1, `pin_init` = bit 2 (not inverted), `pin_selin` = NOT bit 3.
- R7: A read of the control register returns bits 7 and 6 as 1 and bits 5 to 0 as the stored control bits.
- R8: A read of the status register returns bits 2 to 0 as 1, bit 3 = `pin_fault`, bit 4 = `pin_slct`, bit 5 = `pin_perr`, bit 6 = `pin_ack` and bit 7 = NOT `pin_busy`. Each value is the pin level `SYNC_STAGES` clocks earlier.
- R9: `irq` is 1 exactly when control bit 4 is 1 and the synchronized `pin_ack` is 0.
- R10: While `rst_n` is low, the data latch and the control register clear to 0. This gives `pd_out` = 0x00, `pd_oe` = 1, `pin_init` = 0, `pin_strobe` = `pin_autofd` = `pin_selin` = 1, and `irq` = 0.
- R11: Offsets 3 and 7 of the window hold no register. A write there changes nothing, and a read there returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Host I/O address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (0xFF when not reading a register) |
| pd_out | output | 8 | Data latch value toward the data pins |
| pd_oe | output | 1 | Output enable of the data pin drivers |
| pd_in | input | 8 | Resolved level on the data pins |
| pin_strobe | output | 1 | Strobe line (pin level) |
| pin_autofd | output | 1 | Auto line feed line (pin level) |
| pin_init | output | 1 | Printer initialise line (pin level) |
| pin_selin | output | 1 | Select-in line (pin level) |
| pin_ack | input | 1 | Acknowledge line from the printer |
| pin_busy | input | 1 | Busy line from the printer |
| pin_perr | input | 1 | Paper end line from the printer |
| pin_slct | input | 1 | Selected line from the printer |
| pin_fault | input | 1 | Error line from the printer |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 10-bit address, base 0x378, alias bit 2 and a two-stage synchronizer. The 10-bit address makes room for a decoy at 0x278, which differs from the base only in a bit that is compared. It also brings the alias at 0x37C–0x37E and the empty offsets 0x37B and 0x37F into the tests. With two synchronizer stages, the status register and the interrupt output react a fixed two clocks after a pin changes, and the bench waits for that latency before it checks them. The bench models the pin resolution itself, so a read in input mode shows the value of the external driver and not the latch.

// File: rtl/lpt_pkg.sv
// Package: shared constants and types for the printer port register block.
// Assumes 8-bit registers and a four-address register window.
package lpt_pkg;
    localparam int DATA_W = 8;
    localparam int CTRL_W = 6;

    // Control bit positions (software-visible, fixed)
    localparam int CB_STROBE = 0;
    localparam int CB_AUTOFD = 1;
    localparam int CB_INIT   = 2;
    localparam int CB_SELIN  = 3;
    localparam int CB_IEN    = 4;
    localparam int CB_DIR    = 5;

    // Register selected by the low two address bits
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } lpt_sel_e;
endpackage

// File: rtl/lpt_addr_dec.sv
// Module: lpt_addr_dec
// Compares the host address with the base address. The low two offset bits
// and the alias bit are left out of the compare. Assumes that the base address
// has those bits cleared.
module lpt_addr_dec
    import lpt_pkg::*;
#(
    parameter int                ADDR_W    = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h378,
    parameter int                ALIAS_BIT = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output lpt_sel_e          sel
);
    localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] IGN_MASK = OFS_MASK | (ADDR_W'(1) << ALIAS_BIT);
    localparam logic [ADDR_W-1:0] BASE_CMP = BASE_ADDR & ~IGN_MASK;

    // Window match and register select
    always_comb begin
        hit = ((addr & ~IGN_MASK) == BASE_CMP);
        sel = lpt_sel_e'(addr[1:0]);
    end
endmodule

// File: rtl/lpt_sync.sv
// Module: lpt_sync
// A multi-stage synchronizer for a vector of asynchronous inputs. Reset loads
// RST_VAL into every stage. Assumes STAGES >= 1.
module lpt_sync #(
    parameter int             W       = 5,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage captures the raw inputs
            always_ff @(posedge clk) begin
                if (!rst_n) stage[0] <= RST_VAL;
                else        stage[0] <= d;
            end
        end else begin : g_next
            // Later stages shift the previous stage along
            always_ff @(posedge clk) begin
                if (!rst_n) stage[i] <= RST_VAL;
                else        stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/lpt_rd_mux.sv
// Module: lpt_rd_mux
// Read data multiplexer. Returns 0xFF when no register is read or when the
// empty offset is read. Assumes that the control register is CTRL_W bits wide
// and that its unused upper bits read as 1.
module lpt_rd_mux
    import lpt_pkg::*;
(
    input  logic              rd_en,
    input  lpt_sel_e          sel,
    input  logic [DATA_W-1:0] pins,
    input  logic [DATA_W-1:0] status,
    input  logic [CTRL_W-1:0] ctrl,
    output logic [DATA_W-1:0] rdata
);
    // Select the byte returned to the host
    always_comb begin
        rdata = '1;
        if (rd_en) begin
            unique case (sel)
                SEL_DATA: rdata = pins;
                SEL_STAT: rdata = status;
                SEL_CTRL: rdata = {{(DATA_W-CTRL_W){1'b1}}, ctrl};
                SEL_NONE: rdata = '1;
            endcase
        end
    end
endmodule

// File: rtl/lpt_port.sv
// Module: lpt_port (top)
// Printer port register block: data latch, control register and status view
// behind a host I/O window, with a bidirectional data direction bit.
// Assumes a synchronous host strobe interface and asynchronous printer inputs.
module lpt_port
    import lpt_pkg::*;
#(
    parameter int                ADDR_W      = 10,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 10'h378,
    parameter int                ALIAS_BIT   = 2,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [7:0]        pd_out,
    output logic              pd_oe,
    input  logic [7:0]        pd_in,
    output logic              pin_strobe,
    output logic              pin_autofd,
    output logic              pin_init,
    output logic              pin_selin,
    input  logic              pin_ack,
    input  logic              pin_busy,
    input  logic              pin_perr,
    input  logic              pin_slct,
    input  logic              pin_fault,
    output logic              irq
);
    localparam int STAT_IN_W = 5;

    logic              dec_hit;
    lpt_sel_e          dec_sel;
    logic [DATA_W-1:0] data_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [STAT_IN_W-1:0] stat_raw;
    logic [STAT_IN_W-1:0] stat_s;
    logic [DATA_W-1:0] status;
    logic              wr_data;
    logic              wr_ctrl;

    lpt_addr_dec #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .ALIAS_BIT (ALIAS_BIT)
    ) u_dec (
        .addr (bus_addr),
        .hit  (dec_hit),
        .sel  (dec_sel)
    );

    // Write enables per register
    always_comb begin
        wr_data = bus_wr && dec_hit && (dec_sel == SEL_DATA);
        wr_ctrl = bus_wr && dec_hit && (dec_sel == SEL_CTRL);
    end

    // Data latch feeding the data pins
    always_ff @(posedge clk) begin
        if (!rst_n)       data_q <= '0;
        else if (wr_data) data_q <= bus_wdata;
    end

    // Control register: handshake bits, interrupt enable, direction
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
    end

    assign stat_raw = {pin_busy, pin_ack, pin_perr, pin_slct, pin_fault};

    lpt_sync #(
        .W       (STAT_IN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (stat_raw),
        .q     (stat_s)
    );

    // Status byte: busy inverted, low three bits fixed high
    assign status = {~stat_s[4], stat_s[3:0], 3'b111};

    lpt_rd_mux u_rd (
        .rd_en  (bus_rd && dec_hit),
        .sel    (dec_sel),
        .pins   (pd_in),
        .status (status),
        .ctrl   (ctrl_q),
        .rdata  (bus_rdata)
    );

    // Pin drive with the fixed output polarity
    assign pd_out     = data_q;
    assign pd_oe      = ~ctrl_q[CB_DIR];
    assign pin_strobe = ~ctrl_q[CB_STROBE];
    assign pin_autofd = ~ctrl_q[CB_AUTOFD];
    assign pin_init   =  ctrl_q[CB_INIT];
    assign pin_selin  = ~ctrl_q[CB_SELIN];
    assign irq        =  ctrl_q[CB_IEN] & ~stat_s[3];
endmodule

// File: rtl/lpt_port_checker.sv
// Module: lpt_port_checker
// Property checker for lpt_port, attached with bind. It checks register write
// effects at the pins and the fixed read values.
module lpt_port_checker
    import lpt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       hit,
    input logic [1:0] sel,
    input logic [7:0] pd_out,
    input logic       pd_oe,
    input logic       pin_strobe,
    input logic       pin_autofd,
    input logic       pin_init,
    input logic       pin_selin,
    input logic       irq
);
    logic wr_d, wr_c;
    assign wr_d = bus_wr && hit && (sel == 2'd0);
    assign wr_c = bus_wr && hit && (sel == 2'd2);

    AST_DATA_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_d |=> pd_out == $past(bus_wdata)); // R3
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_d |=> $stable(pd_out)); // R3
    AST_DIR_OE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_c |=> pd_oe == !$past(bus_wdata[5])); // R4
    AST_INIT_POL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_c |=> pin_init == $past(bus_wdata[2])); // R6
    AST_INV_POL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_c |=> (pin_strobe == !$past(bus_wdata[0])) && (pin_autofd == !$past(bus_wdata[1]))
                 && (pin_selin == !$past(bus_wdata[3]))); // R6
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c && !bus_wdata[4]) |=> !irq); // R9
    AST_MISS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit) |-> bus_rdata == 8'hFF); // R1
    AST_CTRL_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit && sel == 2'd2) |-> bus_rdata[7:6] == 2'b11); // R7
endmodule

bind lpt_port lpt_port_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .hit        (dec_hit),
    .sel        (dec_sel),
    .pd_out     (pd_out),
    .pd_oe      (pd_oe),
    .pin_strobe (pin_strobe),
    .pin_autofd (pin_autofd),
    .pin_init   (pin_init),
    .pin_selin  (pin_selin),
    .irq        (irq)
);

// File: tb/test_lpt_port.sv
`timescale 1ns/1ps
module test_lpt_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pd_out;
    logic       pd_oe;
    logic [7:0] pd_in;
    logic [7:0] ext_drv = 8'h00;
    logic       pin_strobe, pin_autofd, pin_init, pin_selin, irq;
    logic       pin_ack = 1'b1, pin_busy = 1'b0, pin_perr = 1'b0;
    logic       pin_slct = 1'b0, pin_fault = 1'b0;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    // Resolved pin level: the latch when enabled, else the external driver
    assign pd_in = pd_oe ? pd_out : ext_drv;

    lpt_port i_lpt_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in),
        .pin_strobe(pin_strobe), .pin_autofd(pin_autofd), .pin_init(pin_init),
        .pin_selin(pin_selin), .pin_ack(pin_ack), .pin_busy(pin_busy),
        .pin_perr(pin_perr), .pin_slct(pin_slct), .pin_fault(pin_fault), .irq(irq)
    );

    // Row: {write, addr[9:0], wdata[7:0], expected[7:0], requirement[3:0]}
    localparam int NV = 16;
    localparam logic [30:0] VEC [NV] = '{
        {1'b1, 10'h378, 8'hA5, 8'h00, 4'd3},  // R3 load latch
        {1'b0, 10'h378, 8'h00, 8'hA5, 4'd5},  // R5 read pins
        {1'b0, 10'h37C, 8'h00, 8'hA5, 4'd2},  // R2 alias data
        {1'b1, 10'h37C, 8'h3C, 8'h00, 4'd2},  // R2 write via alias
        {1'b0, 10'h378, 8'h00, 8'h3C, 4'd2},
        {1'b1, 10'h37A, 8'h15, 8'h00, 4'd7},
        {1'b0, 10'h37A, 8'h00, 8'hD5, 4'd7},  // R7 control readback
        {1'b0, 10'h37E, 8'h00, 8'hD5, 4'd2},
        {1'b1, 10'h37B, 8'hFF, 8'h00, 4'd11}, // R11 empty offset
        {1'b0, 10'h37B, 8'h00, 8'hFF, 4'd11},
        {1'b0, 10'h37A, 8'h00, 8'hD5, 4'd11},
        {1'b1, 10'h278, 8'h00, 8'h00, 4'd1},  // R1 outside window
        {1'b0, 10'h378, 8'h00, 8'h3C, 4'd1},
        {1'b0, 10'h278, 8'h00, 8'hFF, 4'd1},
        {1'b1, 10'h37E, 8'h0A, 8'h00, 4'd2},
        {1'b0, 10'h37A, 8'h00, 8'hCA, 4'd2}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pins_out(output logic [7:0] v);
        v = {4'b0, pin_selin, pin_init, pin_autofd, pin_strobe};
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] r;
        logic [7:0] pv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 pd_out", pd_out, 8'h00);
        chk("R10 oe", {7'b0, pd_oe}, 8'h01);
        pins_out(pv);
        chk("R10 pins selin/init/autofd/strobe", pv, 8'h0B);
        chk("R10 irq", {7'b0, irq}, 8'h00);
        bus_read(10'h37A, r); chk("R10 ctrl read", r, 8'hC0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][30]) bus_write(VEC[i][29:20], VEC[i][19:12]);
            else begin
                bus_read(VEC[i][29:20], r);
                chk($sformatf("R%0d vec %0d", VEC[i][3:0], i), r, VEC[i][11:4]);
            end
        end

        // R6 polarity: ctrl=0x0B sets all inverted lines low, init low
        bus_write(10'h37A, 8'h0B);
        pins_out(pv); chk("R6 pins 0B", pv, 8'h00);
        bus_write(10'h37A, 8'h04);
        pins_out(pv); chk("R6 pins 04", pv, 8'h0F);

        // R4 direction and R5 input-mode read
        bus_write(10'h378, 8'h3C);
        ext_drv = 8'h5A;
        bus_write(10'h37A, 8'h20);
        chk("R4 oe off", {7'b0, pd_oe}, 8'h00);
        bus_read(10'h378, r); chk("R5 input read", r, 8'h5A);
        bus_write(10'h378, 8'h81);
        chk("R4 latch loads in input mode", pd_out, 8'h81);
        bus_read(10'h378, r); chk("R5 still external", r, 8'h5A);
        bus_write(10'h37A, 8'h00);
        chk("R4 oe on", {7'b0, pd_oe}, 8'h01);
        bus_read(10'h378, r); chk("R5 output read", r, 8'h81);

        // R8 status layout
        pin_fault = 1; pin_slct = 1; pin_perr = 0; pin_ack = 1; pin_busy = 1;
        repeat (3) @(negedge clk);
        bus_read(10'h379, r); chk("R8 status a", r, 8'h5F);
        pin_fault = 0; pin_slct = 0; pin_perr = 1; pin_ack = 0; pin_busy = 0;
        repeat (3) @(negedge clk);
        bus_read(10'h37D, r); chk("R8 status b via alias", r, 8'hA7);

        // R9 interrupt gating
        chk("R9 irq masked", {7'b0, irq}, 8'h00);
        bus_write(10'h37A, 8'h10);
        chk("R9 irq on", {7'b0, irq}, 8'h01);
        pin_ack = 1;
        repeat (3) @(negedge clk);
        chk("R9 irq ack high", {7'b0, irq}, 8'h00);

        // R10 reset mid-run
        bus_write(10'h378, 8'hEE);
        bus_write(10'h37A, 8'h2F);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R10 data after reset", pd_out, 8'h00);
        chk("R10 oe after reset", {7'b0, pd_oe}, 8'h01);
        bus_read(10'h37A, r); chk("R10 ctrl after reset", r, 8'hC0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule